// File: doc/BRIEF.md
# Two-Phase Soft-Start Sequencer

This block orders the power-up of a primary-side switching controller on a slow timebase. A single-cycle timebase tick arrives every half millisecond. In the idle state the high-voltage bias path is kept on, so the supply capacitor can charge. When the supply-good input asserts, the block enters the first startup phase and starts a bias hold-off timer. This timer turns the bias path off once a fixed number of ticks has passed.

The first phase opens with a short CCM-prevent window, which tells the power stage to use a reduced current limit and a fixed low switching frequency. During this phase the block also ramps an 8-bit duty-ceiling code. The phase ends when the loop-compensation comparator reports that the node has fallen below its threshold. If that never happens, a timeout ends it. The second phase waits a fixed settle time. It then waits for an input-peak pulse and a short delay after that pulse, and finally raises a sticky done flag. Proportional gain is selected through both phases and released afterwards.

All durations are counted in ticks of 0.5 ms. The defaults are 1000 ticks (500 ms) for the bias hold-off, 4 ticks (2 ms) for the CCM window, 52 ticks (26 ms) for the ramp, 200 ticks (100 ms) for the first-phase limit, 90 ticks (45 ms) for the settle time and 3 ticks (1.5 ms) for the post-peak delay. A drop of the supply-good input returns the block to idle from any state.

Top module: `startup_sequencer`

## Requirements
- R1: After reset, and whenever idle, biasEn=1, ccmPrevent=0, rampCeil=0, pGainSel=0, inSs1=0, inSs2=0 and seqDone=0.
- R2: biasEn falls at the clock edge that counts the 1000th tick since leaving idle, and stays 0 until the block is idle again.
- R3: In idle, supplyOk=1 sampled at an edge puts the block in phase one (inSs1=1) from that edge on.
- R4: ccmPrevent=1 exactly while in phase one and fewer than 4 ticks have been counted since phase-one entry.
- R5: In phase one rampCeil = floor(255*min(n,52)/52), where n is the number of ticks counted since entry (a tick on the entry edge is not counted). In phase two and after done, rampCeil=255.
- R6: comvLow=1 in phase one moves the block to phase two (inSs1=0, inSs2=1) at the next edge.
- R7: If comvLow stays 0, phase one ends at the edge of its 200th counted tick.
- R8: pGainSel=1 exactly while in phase one or phase two.
- R9: Phase two first counts 90 ticks. peakPulse during this settle time is ignored: seqDone stays 0 and inSs2 stays 1.
- R10: After the settle time, a peakPulse starts a 3-tick delay, and seqDone=1 (inSs2=0) from the edge of the 3rd tick.
- R11: supplyOk=0 at any edge returns the block to idle, clears both timers, and re-enables bias.
- R12: seqDone stays 1 while supplyOk stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle timebase pulse, one every 0.5 ms |
| supplyOk | input | 1 | Supply above its on threshold |
| comvLow | input | 1 | Compensation node below its exit threshold |
| peakPulse | input | 1 | Input-voltage peak detected |
| biasEn | output | 1 | High-voltage bias enable |
| ccmPrevent | output | 1 | Reduced current limit and fixed low frequency |
| rampCeil | output | 8 | Duty ceiling code |
| pGainSel | output | 1 | Proportional-gain select |
| inSs1 | output | 1 | First startup phase active |
| inSs2 | output | 1 | Second startup phase active |
| seqDone | output | 1 | Startup complete |

## Verification
Every output is decoded from registers only, so an input value sampled at an edge shows up at the ports one clock later. A tick that completes a timer likewise moves the outputs at that same edge. The bench applies each input set just after a falling edge and compares all seven outputs at the next falling edge. That point is half a cycle after the rising edge that consumed the inputs. The bench's model is advanced by exactly one step per applied input set, so each comparison lines up with the cycle in which the result is due. The tick runs every third clock, which places timer boundaries at many different positions relative to the other inputs.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SS1    = 3'd1,
    ST_SETTLE = 3'd2,
    ST_WAITPK = 3'd3,
    ST_DELAY  = 3'd4,
    ST_DONE   = 3'd5
  } seqState_t;

  typedef enum logic [1:0] {
    RAMP_OFF  = 2'd0,
    RAMP_RUN  = 2'd1,
    RAMP_FULL = 2'd2
  } rampMode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic      clrPhase;
    logic      clrBias;
    logic      runBias;
    logic      ccmEnable;
    rampMode_t rampMode;
  } dpStrobe_t;

  // datapath -> control terminal-count flags
  typedef struct packed {
    logic ss1Expired;
    logic settleDone;
    logic delayDone;
  } dpStatus_t;

endpackage

// File: rtl/startup_seq_dpath.sv
module startup_seq_dpath
  import startup_seq_pkg::*;
#(
  parameter int BIAS_TICKS   = 1000,
  parameter int CCM_TICKS    = 4,
  parameter int RAMP_TICKS   = 52,
  parameter int SS1_TICKS    = 200,
  parameter int SETTLE_TICKS = 90,
  parameter int DELAY_TICKS  = 3,
  parameter int CODE_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  dpStrobe_t         strobe,
  output dpStatus_t         status,
  output logic              biasEn,
  output logic              ccmPrevent,
  output logic [CODE_W-1:0] rampCeil
);

  localparam int MAX_A   = (SS1_TICKS > SETTLE_TICKS) ? SS1_TICKS : SETTLE_TICKS;
  localparam int MAX_B   = (RAMP_TICKS > DELAY_TICKS) ? RAMP_TICKS : DELAY_TICKS;
  localparam int PH_MAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int BIAS_W  = $clog2(BIAS_TICKS + 1);
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic [PH_W-1:0]   phaseCnt;
  logic [BIAS_W-1:0] biasCnt;
  logic [PH_W-1:0]   rampPos;

  // phase timer, restarted on every state change, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strobe.clrPhase) begin
      phaseCnt <= '0;
    end else if (msTick && (phaseCnt != PH_W'(PH_MAX))) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // bias hold-off timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      biasCnt <= '0;
    end else if (strobe.clrBias) begin
      biasCnt <= '0;
    end else if (strobe.runBias && msTick && (biasCnt != BIAS_W'(BIAS_TICKS))) begin
      biasCnt <= biasCnt + 1'b1;
    end
  end

  assign biasEn = (biasCnt != BIAS_W'(BIAS_TICKS));

  always_comb begin
    status.ss1Expired = msTick && (phaseCnt == PH_W'(SS1_TICKS - 1));
    status.settleDone = msTick && (phaseCnt == PH_W'(SETTLE_TICKS - 1));
    status.delayDone  = msTick && (phaseCnt == PH_W'(DELAY_TICKS - 1));
  end

  assign ccmPrevent = strobe.ccmEnable && (phaseCnt < PH_W'(CCM_TICKS));

  // duty ceiling: linear ramp to full scale, then hold
  always_comb begin
    rampPos = (phaseCnt > PH_W'(RAMP_TICKS)) ? PH_W'(RAMP_TICKS) : phaseCnt;
    unique case (strobe.rampMode)
      RAMP_RUN:  rampCeil = CODE_W'((32'(rampPos) * 32'(CODE_MAX)) / 32'(RAMP_TICKS));
      RAMP_FULL: rampCeil = CODE_W'(CODE_MAX);
      default:   rampCeil = '0;
    endcase
  end

  // R2: once the bias is off it stays off until the timer is cleared
  a_r2_bias_stays_off : assert property (@(posedge clk) disable iff (!rstN)
    (!biasEn && !strobe.clrBias) |=> !biasEn);

  // R4: CCM prevent window never reaches past its tick limit
  a_r4_ccm_short : assert property (@(posedge clk) disable iff (!rstN)
    (ccmPrevent && msTick && !strobe.clrPhase && (phaseCnt == PH_W'(CCM_TICKS - 1))) |=> !ccmPrevent);

endmodule

// File: rtl/startup_seq_ctrl.sv
module startup_seq_ctrl
  import startup_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyOk,
  input  logic      comvLow,
  input  logic      peakPulse,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      pGainSel,
  output logic      inSs1,
  output logic      inSs2,
  output logic      seqDone
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (supplyOk) nextState = ST_SS1;
      ST_SS1:    if (comvLow || status.ss1Expired) nextState = ST_SETTLE;
      ST_SETTLE: if (status.settleDone) nextState = ST_WAITPK;
      ST_WAITPK: if (peakPulse) nextState = ST_DELAY;
      ST_DELAY:  if (status.delayDone) nextState = ST_DONE;
      ST_DONE:   nextState = ST_DONE;
      default:   nextState = ST_IDLE;
    endcase
    if (!supplyOk) nextState = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe.clrPhase  = (nextState != state) || (state == ST_IDLE);
    strobe.clrBias   = (state == ST_IDLE) || !supplyOk;
    strobe.runBias   = (state != ST_IDLE);
    strobe.ccmEnable = (state == ST_SS1);
    unique case (state)
      ST_IDLE: strobe.rampMode = RAMP_OFF;
      ST_SS1:  strobe.rampMode = RAMP_RUN;
      default: strobe.rampMode = RAMP_FULL;
    endcase
  end

  assign inSs1    = (state == ST_SS1);
  assign inSs2    = (state == ST_SETTLE) || (state == ST_WAITPK) || (state == ST_DELAY);
  assign pGainSel = inSs1 || inSs2;
  assign seqDone  = (state == ST_DONE);

  // R11: supply loss forces idle
  a_r11_drop_to_idle : assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (state == ST_IDLE));

  // R3: supply good leaves idle for phase one
  a_r3_start : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && supplyOk) |=> (state == ST_SS1));

  // R9: settle is not cut short by a peak
  a_r9_settle_hold : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETTLE && supplyOk && !status.settleDone) |=> (state == ST_SETTLE));

  // R12: done is sticky while supply is good
  a_r12_done_hold : assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && supplyOk) |=> seqDone);

endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
  import startup_seq_pkg::*;
#(
  parameter int BIAS_TICKS   = 1000,
  parameter int CCM_TICKS    = 4,
  parameter int RAMP_TICKS   = 52,
  parameter int SS1_TICKS    = 200,
  parameter int SETTLE_TICKS = 90,
  parameter int DELAY_TICKS  = 3,
  parameter int CODE_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic              supplyOk,
  input  logic              comvLow,
  input  logic              peakPulse,
  output logic              biasEn,
  output logic              ccmPrevent,
  output logic [CODE_W-1:0] rampCeil,
  output logic              pGainSel,
  output logic              inSs1,
  output logic              inSs2,
  output logic              seqDone
);

  dpStrobe_t strobe;
  dpStatus_t status;

  startup_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .supplyOk  (supplyOk),
    .comvLow   (comvLow),
    .peakPulse (peakPulse),
    .status    (status),
    .strobe    (strobe),
    .pGainSel  (pGainSel),
    .inSs1     (inSs1),
    .inSs2     (inSs2),
    .seqDone   (seqDone)
  );

  startup_seq_dpath #(
    .BIAS_TICKS   (BIAS_TICKS),
    .CCM_TICKS    (CCM_TICKS),
    .RAMP_TICKS   (RAMP_TICKS),
    .SS1_TICKS    (SS1_TICKS),
    .SETTLE_TICKS (SETTLE_TICKS),
    .DELAY_TICKS  (DELAY_TICKS),
    .CODE_W       (CODE_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .msTick     (msTick),
    .strobe     (strobe),
    .status     (status),
    .biasEn     (biasEn),
    .ccmPrevent (ccmPrevent),
    .rampCeil   (rampCeil)
  );

  // R5: ceiling never falls while phase one continues
  a_r5_ramp_rises : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rampMode == RAMP_RUN && supplyOk) |=> (rampCeil >= $past(rampCeil)));

  // R4, R8: CCM prevent only happens under proportional gain
  a_r4_ccm_in_pgain : assert property (@(posedge clk) disable iff (!rstN)
    ccmPrevent |-> pGainSel);

endmodule

// File: tb/startup_sequencer_tb_top.sv
module startup_sequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0, supplyOk = 1'b0, comvLow = 1'b0, peakPulse = 1'b0;
  logic biasEn, ccmPrevent, pGainSel, inSs1, inSs2, seqDone;
  logic [7:0] rampCeil;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  // reference state: 0 idle, 1 ss1, 2 settle, 3 wait peak, 4 delay, 5 done
  int mState = 0, mPh = 0, mBias = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  startup_sequencer dut_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .supplyOk(supplyOk),
    .comvLow(comvLow), .peakPulse(peakPulse), .biasEn(biasEn),
    .ccmPrevent(ccmPrevent), .rampCeil(rampCeil), .pGainSel(pGainSel),
    .inSs1(inSs1), .inSs2(inSs2), .seqDone(seqDone)
  );

  function automatic int expCeil(int st, int ph);
    int p;
    if (st == 0) return 0;
    if (st != 1) return 255;
    p = (ph > 52) ? 52 : ph;
    return (255 * p) / 52;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("R2 biasEn", int'(biasEn), (mBias != 1000) ? 1 : 0);
    chk("R4 ccmPrevent", int'(ccmPrevent), (mState == 1 && mPh < 4) ? 1 : 0);
    chk("R5 rampCeil", int'(rampCeil), expCeil(mState, mPh));
    chk("R8 pGainSel", int'(pGainSel), (mState >= 1 && mState <= 4) ? 1 : 0);
    chk("R3/R6/R7/R11 inSs1", int'(inSs1), (mState == 1) ? 1 : 0);
    chk("R9 inSs2", int'(inSs2), (mState >= 2 && mState <= 4) ? 1 : 0);
    chk("R10/R12 seqDone", int'(seqDone), (mState == 5) ? 1 : 0);
  endtask

  task automatic advanceModel(bit sup, bit comv, bit pk, bit tk);
    int nxt;
    nxt = mState;
    case (mState)
      0: if (sup) nxt = 1;
      1: if (comv || (tk && mPh == 199)) nxt = 2;
      2: if (tk && mPh == 89) nxt = 3;
      3: if (pk) nxt = 4;
      4: if (tk && mPh == 2) nxt = 5;
      default: nxt = mState;
    endcase
    if (!sup) nxt = 0;
    if (mState == 0 || !sup) mBias = 0;
    else if (tk && mBias < 1000) mBias++;
    if (nxt != mState || mState == 0) mPh = 0;
    else if (tk && mPh < 255) mPh++;
    mState = nxt;
  endtask

  // one clock: compare, then apply inputs for the next rising edge
  task automatic step(bit sup, bit comv, bit pk);
    bit tk;
    @(negedge clk);
    checkAll();
    tk = (cyc % TICK_GAP) == 0;
    msTick = tk; supplyOk = sup; comvLow = comv; peakPulse = pk;
    advanceModel(sup, comv, pk, tk);
    cyc++;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    int dropLeft;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state observed in idle
    step(0, 0, 0);
    step(0, 0, 0);
    // R3, R4, R5, R7: no comparator exit, phase one runs to timeout
    for (int i = 0; i < 650; i++) step(1, 0, 0);
    // R9: peak during settle is ignored
    step(1, 0, 1);
    for (int i = 0; i < 300; i++) step(1, 0, 0);
    // R10: peak after settle, done after delay
    step(1, 0, 1);
    for (int i = 0; i < 20; i++) step(1, 0, 0);
    // R2, R12: bias times out, done holds
    for (int i = 0; i < 3000; i++) step(1, 0, 0);
    // R11: supply drop from done
    step(0, 0, 0);
    step(0, 0, 0);
    // R6: early comparator exit during ramp
    for (int i = 0; i < 40; i++) step(1, 0, 0);
    step(1, 1, 0);
    for (int i = 0; i < 20; i++) step(1, 0, 0);
    // R11: drop in phase two
    step(0, 0, 0);
    // random mix
    dropLeft = 0;
    for (int i = 0; i < 60000; i++) begin
      bit sup;
      if (dropLeft > 0) begin
        sup = 0;
        dropLeft--;
      end else begin
        sup = 1;
        if ($urandom % 4000 == 0) dropLeft = 5 + int'($urandom % 40);
      end
      step(sup, ($urandom % 400) == 0, ($urandom % 50) == 0);
    end
    step(1, 0, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule